// File: doc/BRIEF.md
# Camera Mode Controller

This block decides what a camera shows and when it writes a frame to storage. A live view switch, a shutter button and a resume button come in from the user. Start-of-frame pulses come in from the sensor path. Out go a storage write strobe, a display source select, a freeze flag and the index of the stored image slot in use. The block switches mode only on a start-of-frame pulse, so neither a stored picture nor a displayed frame is ever cut part way through.

In live view, sensor frames go straight to the display. A shutter press schedules one capture. The next whole frame is written to the current slot. The block then freezes and keeps showing that picture until the user presses resume. While the switch is high, the display shows stored pictures, and each shutter press steps to the next slot. Storage holds as many pictures as fit: the memory size divided by the size of one reduced picture, which is six with the default values. The switch takes priority over every other request.

Top module: `cam_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (live), `store_we`, `show_stored` and `freeze` are low, and `slot` is 0.
- R2: A button acts only after its synchronised level has been high for DEB_CYCLES consecutive clocks. A shorter pulse has no effect on `mode`.
- R3: A shutter press in live mode (`mode` 0) moves to `mode` 1 (capturing) at the next `sof`. From that `sof` until the following one, `store_we` is high and `slot` gives the slot being written.
- R4: At the `sof` that ends a capturing frame, the block enters `mode` 2 (frozen) with `freeze` and `show_stored` high, `store_we` low, and `slot` equal to the slot just written.
- R5: In frozen mode a shutter press has no effect. A resume press returns the block to `mode` 0 at the next `sof`.
- R6: The write slot starts at 0 and advances by one after each completed capture. It wraps from SLOTS-1 (5 by default) back to 0. In live mode `slot` shows the next slot to be written.
- R7: A high switch moves the block to `mode` 3 (playback) at the next `sof`, with `show_stored` high and `freeze` low. A low switch returns it to `mode` 0 at the next `sof`. Between `sof` pulses the mode does not change.
- R8: In playback, `slot` starts at the most recently captured slot. Each shutter press advances it by one, modulo SLOTS, at the next `sof`. A resume press has no effect on it.
- R9: `mode` changes only in the cycle after a clock edge at which `sof` was high.
- R10: The switch overrides other requests. At a `sof` in live mode with a capture pending, or in frozen mode, a high switch selects playback.
- R11: A capture under way always completes. If the switch is high at the `sof` that ends the capture, the block goes to playback instead of frozen, and the new picture is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_sw | input | 1 | Playback switch, asynchronous level |
| cap_btn | input | 1 | Shutter button, asynchronous, bouncy |
| res_btn | input | 1 | Resume button, asynchronous, bouncy |
| sof | input | 1 | One-cycle start-of-frame pulse |
| store_we | output | 1 | Frame storage write enable |
| show_stored | output | 1 | Display source: 1 = stored image, 0 = live sensor |
| freeze | output | 1 | Hold the captured picture on screen |
| slot | output | 3 | Active stored image slot |
| mode | output | 2 | 0 live, 1 capturing, 2 frozen, 3 playback |

## Verification
The assertions assume that `sof` is a clean one-cycle pulse from the synchronous frame logic and that reset is held for at least one clock edge. They place no demands on the buttons or the switch, because the block synchronises those itself. The stimulus drives `sof` for exactly one clock, a few dozen cycles apart. It changes buttons and the switch only between frames and holds each change long enough to pass synchronisation and debounce before the next `sof`. As a result, no check depends on a press and a frame start landing on the same edge.

// File: rtl/cam_mode_ctrl.sv
module cam_mode_ctrl #(
  parameter int MEM_BYTES  = 524288,
  parameter int IMG_BYTES  = 76800,
  parameter int DEB_CYCLES = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    play_sw,
  input  logic                                    cap_btn,
  input  logic                                    res_btn,
  input  logic                                    sof,
  output logic                                    store_we,
  output logic                                    show_stored,
  output logic                                    freeze,
  output logic [$clog2(MEM_BYTES/IMG_BYTES)-1:0]  slot,
  output logic [1:0]                              mode
);
  localparam int SLOTS = MEM_BYTES / IMG_BYTES;
  localparam int SW    = $clog2(SLOTS);
  localparam int CW    = $clog2(DEB_CYCLES + 1);

  typedef enum logic [1:0] {LIVE = 2'd0, CAPT = 2'd1, FROZ = 2'd2, PLAY = 2'd3} state_t;

  state_t          st;
  logic [1:0]      bsync0, bsync1, deb, press;
  logic [CW-1:0]   cnt [2];
  logic            sw0, sw1;
  logic            cap_pend, res_pend;
  logic [SW-1:0]   wr_slot, rd_slot;
  logic            cap_req, res_req;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] s);
    return (s == SW'(SLOTS - 1)) ? '0 : s + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsync0 <= '0;
      bsync1 <= '0;
      deb    <= '0;
      press  <= '0;
      sw0    <= 1'b0;
      sw1    <= 1'b0;
      for (int i = 0; i < 2; i++) cnt[i] <= '0;
    end else begin
      bsync0 <= {res_btn, cap_btn};
      bsync1 <= bsync0;
      sw0    <= play_sw;
      sw1    <= sw0;
      for (int i = 0; i < 2; i++) begin
        press[i] <= 1'b0;
        if (bsync1[i] == deb[i]) begin
          cnt[i] <= '0;
        end else if (cnt[i] == CW'(DEB_CYCLES - 1)) begin
          cnt[i]   <= '0;
          deb[i]   <= bsync1[i];
          press[i] <= bsync1[i];
        end else begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  end

  assign cap_req = cap_pend | press[0];
  assign res_req = res_pend | press[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= LIVE;
      cap_pend <= 1'b0;
      res_pend <= 1'b0;
      wr_slot  <= '0;
      rd_slot  <= '0;
    end else if (sof) begin
      cap_pend <= 1'b0;
      res_pend <= 1'b0;
      unique case (st)
        LIVE: if (sw1) st <= PLAY; else if (cap_req) st <= CAPT;
        CAPT: begin
          rd_slot <= wr_slot;
          wr_slot <= nxt(wr_slot);
          st      <= sw1 ? PLAY : FROZ;
        end
        FROZ: if (sw1) st <= PLAY; else if (res_req) st <= LIVE;
        PLAY: if (!sw1) st <= LIVE; else if (cap_req) rd_slot <= nxt(rd_slot);
      endcase
    end else begin
      cap_pend <= cap_pend | (press[0] & (st == LIVE || st == PLAY));
      res_pend <= res_pend | (press[1] & (st == FROZ));
    end
  end

  assign mode        = st;
  assign store_we    = (st == CAPT);
  assign freeze      = (st == FROZ);
  assign show_stored = (st == FROZ) || (st == PLAY);
  assign slot        = show_stored ? rd_slot : wr_slot;
endmodule

// File: rtl/cam_mode_ctrl_chk.sv
module cam_mode_ctrl_chk #(
  parameter int SLOTS = 6,
  parameter int SW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sof,
  input logic          store_we,
  input logic          show_stored,
  input logic          freeze,
  input logic [SW-1:0] slot,
  input logic [1:0]    mode
);
  AST_MODE_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(sof));                                        // R9
  AST_CAPT_FROM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_we) |-> $past(mode) == 2'd0);                             // R3
  AST_CAPT_ENDS_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(store_we) |-> show_stored);                                     // R11
  AST_CAPT_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(store_we) |-> slot == $past(slot));                             // R4
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && $past(freeze) && !$past(sof)) |-> $stable(slot));          // R5
  AST_PLAY_EXIT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd3 && mode != 2'd3) |-> mode == 2'd0);              // R7
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot < SW'(SLOTS));                                                   // R6
endmodule

bind cam_mode_ctrl cam_mode_ctrl_chk #(.SLOTS(SLOTS), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .store_we(store_we),
  .show_stored(show_stored), .freeze(freeze), .slot(slot), .mode(mode)
);

// File: tb/cam_mode_ctrl_test.sv
module cam_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic play_sw = 1'b0, cap_btn = 1'b0, res_btn = 1'b0, sof = 1'b0;
  logic store_we, show_stored, freeze;
  logic [2:0] slot;
  logic [1:0] mode;
  int checks = 0, fails = 0;

  cam_mode_ctrl #(.DEB_CYCLES(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .play_sw(play_sw), .cap_btn(cap_btn),
    .res_btn(res_btn), .sof(sof), .store_we(store_we), .show_stored(show_stored),
    .freeze(freeze), .slot(slot), .mode(mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame();
    @(negedge clk) sof = 1'b1;
    @(negedge clk) sof = 1'b0;
    idle(3);
  endtask

  task automatic push(input bit res);
    @(negedge clk);
    if (res) res_btn = 1'b1; else cap_btn = 1'b1;
    idle(DEB + 8);
    res_btn = 1'b0;
    cap_btn = 1'b0;
    idle(DEB + 8);
  endtask

  task automatic set_sw(input logic v);
    @(negedge clk) play_sw = v;
    idle(5);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 store_we", store_we, 0);
    chk("R1 show_stored", show_stored, 0);
    chk("R1 freeze", freeze, 0);
    chk("R1 slot", slot, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk) cap_btn = 1'b1;
    idle(2);
    cap_btn = 1'b0;
    idle(DEB + 8);
    frame();
    chk("R2 short pulse ignored", mode, 0);
  endtask

  task automatic t_capture();
    push(0);
    chk("R9 no change before sof", mode, 0);
    frame();
    chk("R3 capturing", mode, 1);
    chk("R3 store_we", store_we, 1);
    chk("R3 slot written", slot, 0);
    idle(20);
    chk("R3 store_we whole frame", store_we, 1);
    frame();
    chk("R4 frozen", mode, 2);
    chk("R4 freeze", freeze, 1);
    chk("R4 show_stored", show_stored, 1);
    chk("R4 store_we off", store_we, 0);
    chk("R4 slot captured", slot, 0);
  endtask

  task automatic t_frozen();
    push(0);
    frame();
    chk("R5 shutter ignored when frozen", mode, 2);
    chk("R5 slot held", slot, 0);
    push(1);
    chk("R9 resume waits for sof", mode, 2);
    frame();
    chk("R5 resume to live", mode, 0);
    chk("R6 next write slot", slot, 1);
  endtask

  task automatic t_wrap();
    for (int k = 1; k < 6; k++) begin
      push(0);
      frame();
      chk("R6 writing slot", slot, k);
      frame();
      chk("R6 frozen slot", slot, k);
      push(1);
      frame();
    end
    chk("R6 wrap to 0", slot, 0);
    chk("R6 live mode", mode, 0);
  endtask

  task automatic t_playback();
    set_sw(1'b1);
    chk("R7 mid-frame switch waits", mode, 0);
    frame();
    chk("R7 playback mode", mode, 3);
    chk("R7 show_stored", show_stored, 1);
    chk("R7 no freeze", freeze, 0);
    chk("R8 starts at last capture", slot, 5);
    push(0);
    frame();
    chk("R8 step wraps", slot, 0);
    push(0);
    frame();
    chk("R8 step", slot, 1);
    push(1);
    frame();
    chk("R8 resume ignored", slot, 1);
    chk("R8 still playback", mode, 3);
    set_sw(1'b0);
    frame();
    chk("R7 back to live", mode, 0);
    chk("R7 live source", show_stored, 0);
  endtask

  task automatic t_override();
    push(0);
    set_sw(1'b1);
    frame();
    chk("R10 switch beats capture", mode, 3);
    chk("R10 no write", store_we, 0);
    set_sw(1'b0);
    frame();
    chk("R10 live again", mode, 0);
    frame();
    chk("R10 pending capture dropped", mode, 0);
    push(0);
    frame();
    chk("R3 capture slot 0", slot, 0);
    frame();
    chk("R4 frozen again", mode, 2);
    set_sw(1'b1);
    frame();
    chk("R10 frozen to playback", mode, 3);
    chk("R10 shows capture", slot, 0);
    set_sw(1'b0);
    frame();
    chk("R6 live slot", slot, 1);
  endtask

  task automatic t_capture_switch();
    push(0);
    frame();
    chk("R11 capturing", store_we, 1);
    set_sw(1'b1);
    chk("R11 capture continues", store_we, 1);
    frame();
    chk("R11 to playback", mode, 3);
    chk("R11 new picture shown", slot, 1);
    set_sw(1'b0);
    frame();
    chk("R11 slot counted", slot, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_glitch();
    t_capture();
    t_frozen();
    t_wrap();
    t_playback();
    t_override();
    t_capture_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule